// File: doc/BRIEF.md
# Register-Controlled Reconfiguration Port Bridge

This block lets software reach the 16-bit reconfiguration port of a clock synthesizer through a plain 32-bit word register bus. Two small configuration registers live beside the port logic. The first holds the core reset release and the synthesizer enable. The second holds the clock source index that steers the output multiplexer. One write to the command register starts exactly one port access, either a read or a write. Software then polls a status word until the busy flag clears. After a read, the same status word carries the returned data.

The register bus has no back-pressure. A write takes effect at the clock edge where `bus_wr` is sampled high. A read returns its data on `bus_rdata` one cycle after `bus_rd` is sampled. On the port side, one transaction is always in flight at most. The bridge raises `drp_en` for one cycle to start it, and it waits for a single-cycle `drp_rdy` from the synthesizer to close it. `drp_rdy` is looked at only in the cycles after the enable pulse. The command sits in the bridge until the port answers, so the synthesizer side never has to buffer anything. Software has to follow the busy flag, because commands sent while busy are dropped.

Top module: `drp_cfg_bridge`

## Requirements
- R1: After reset, `core_rst_n`, `synth_en`, `src_sel`, `drp_en` and `drp_we` are 0, and reads of offsets 0x40, 0x44 and 0x74 return 0.
- R2: A write to offset 0x40 stores bits [1:0]. Bit 0 drives `core_rst_n` (1 releases the core) and bit 1 drives `synth_en`. A read of 0x40 returns the stored bits, with all other bits zero.
- R3: A write to offset 0x44 stores bit 0, which drives `src_sel`. A read of 0x44 returns it, with all other bits zero.
- R4: A write to offset 0x70 with bit 29 set and bit 28 clear, made while idle, starts a port write. `drp_en` and `drp_we` are high together for exactly one cycle, the cycle after the bus write. `drp_addr` equals bits [23:16] and `drp_di` equals bits [15:0].
- R5: A write to offset 0x70 with bits 29 and 28 both set, made while idle, starts a port read. `drp_en` is high for one cycle, `drp_we` stays low, and `drp_addr` equals bits [23:16].
- R6: Status bit 16 (offset 0x74) is set from the edge that accepts a command until the edge that samples `drp_rdy` after the enable pulse.
- R7: When a read completes, `drp_do` is captured into status bits [15:0]. A completing write leaves those bits unchanged.
- R8: A command write while busy is dropped. This includes a write in the very cycle `drp_rdy` returns. A dropped write produces no enable pulse and leaves `drp_addr` unchanged.
- R9: A command write with bit 29 clear starts no transaction.
- R10: Reads of any offset other than 0x40, 0x44 and 0x74 return zero. This includes the write-only command offset 0x70.
- R11: `drp_rdy` while idle has no effect on the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_waddr | input | 8 | Write byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Register read strobe |
| bus_raddr | input | 8 | Read byte offset |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| core_rst_n | output | 1 | Core reset release |
| synth_en | output | 1 | Synthesizer enable |
| src_sel | output | 1 | Clock source index |
| drp_en | output | 1 | Port transaction strobe |
| drp_we | output | 1 | Port write qualifier |
| drp_addr | output | 8 | Port register address |
| drp_di | output | 16 | Port write data |
| drp_do | input | 16 | Port read data |
| drp_rdy | input | 1 | Port completion strobe |

## Verification
Two events can land on the same clock edge: the completion of an outstanding access, carried by `drp_rdy`, and a new command write. The bench drives `drp_rdy` together with a command write to a different address. It then confirms three things: no enable pulse follows, `drp_addr` keeps its old value, and the status word shows the captured read data with busy clear. Once the bridge is idle, a fresh command must be accepted, which shows the drop left no stale state behind.

// File: rtl/drp_bridge_pkg.sv
package drp_bridge_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_ISSUE = 2'd1,
    ENG_WAIT  = 2'd2
  } eng_state_e;

  localparam int CMD_SEL_BIT  = 29;
  localparam int CMD_RD_BIT   = 28;
  localparam int CMD_ADDR_LSB = 16;

endpackage

// File: rtl/cfg_regs.sv
module cfg_regs #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DRP_DW = 16,
  parameter int SEL_W  = 1,
  parameter logic [ADDR_W-1:0] RST_OFFS = 8'h40,
  parameter logic [ADDR_W-1:0] SEL_OFFS = 8'h44,
  parameter logic [ADDR_W-1:0] STS_OFFS = 8'h74
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_waddr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_raddr,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic [DRP_DW-1:0] rd_word,
  output logic              core_rst_n,
  output logic              synth_en,
  output logic [SEL_W-1:0]  src_sel
);

  localparam int BUSY_BIT = DRP_DW;

  logic [1:0]       ctl_q;
  logic [SEL_W-1:0] sel_q;
  logic [DATA_W-1:0] rd_mux;
  logic unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      sel_q <= '0;
    end else if (bus_wr) begin
      if (bus_waddr == RST_OFFS) ctl_q <= bus_wdata[1:0];
      if (bus_waddr == SEL_OFFS) sel_q <= bus_wdata[SEL_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (bus_raddr == RST_OFFS) begin
      rd_mux[1:0] = ctl_q;
    end else if (bus_raddr == SEL_OFFS) begin
      rd_mux[SEL_W-1:0] = sel_q;
    end else if (bus_raddr == STS_OFFS) begin
      rd_mux[BUSY_BIT]     = busy;
      rd_mux[DRP_DW-1:0]   = rd_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign core_rst_n = ctl_q[0];
  assign synth_en   = ctl_q[1];
  assign src_sel    = sel_q;

endmodule

// File: rtl/drp_engine.sv
module drp_engine
  import drp_bridge_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DRP_AW = 8,
  parameter int DRP_DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              busy,
  output logic [DRP_DW-1:0] rd_word,
  output logic              drp_en,
  output logic              drp_we,
  output logic [DRP_AW-1:0] drp_addr,
  output logic [DRP_DW-1:0] drp_di,
  input  logic [DRP_DW-1:0] drp_do,
  input  logic              drp_rdy
);

  eng_state_e state_q, state_d;
  logic       is_rd_q;
  logic       launch;
  logic       finish;
  logic       unused_cmd;

  assign unused_cmd = ^{cmd_data[DATA_W-1:CMD_SEL_BIT+1],
                        cmd_data[CMD_RD_BIT-1:CMD_ADDR_LSB+DRP_AW],
                        cmd_data[CMD_ADDR_LSB-1:DRP_DW]} | 1'b0;

  assign launch = cmd_wr && cmd_data[CMD_SEL_BIT] && (state_q == ENG_IDLE);
  assign finish = (state_q == ENG_WAIT) && drp_rdy;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ENG_IDLE:  if (launch) state_d = ENG_ISSUE;
      ENG_ISSUE: state_d = ENG_WAIT;
      ENG_WAIT:  if (drp_rdy) state_d = ENG_IDLE;
      default:   state_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ENG_IDLE;
      is_rd_q  <= 1'b0;
      drp_addr <= '0;
      drp_di   <= '0;
      rd_word  <= '0;
    end else begin
      state_q <= state_d;
      if (launch) begin
        is_rd_q  <= cmd_data[CMD_RD_BIT];
        drp_addr <= cmd_data[CMD_ADDR_LSB +: DRP_AW];
        drp_di   <= cmd_data[DRP_DW-1:0];
      end
      if (finish && is_rd_q) rd_word <= drp_do;
    end
  end

  assign busy   = (state_q != ENG_IDLE);
  assign drp_en = (state_q == ENG_ISSUE);
  assign drp_we = (state_q == ENG_ISSUE) && !is_rd_q;

endmodule

// File: rtl/drp_cfg_bridge.sv
module drp_cfg_bridge #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DRP_AW = 8,
  parameter int DRP_DW = 16,
  parameter int SEL_W  = 1,
  parameter logic [ADDR_W-1:0] RST_OFFS = 8'h40,
  parameter logic [ADDR_W-1:0] SEL_OFFS = 8'h44,
  parameter logic [ADDR_W-1:0] CMD_OFFS = 8'h70,
  parameter logic [ADDR_W-1:0] STS_OFFS = 8'h74
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_waddr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_raddr,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              core_rst_n,
  output logic              synth_en,
  output logic [SEL_W-1:0]  src_sel,
  output logic              drp_en,
  output logic              drp_we,
  output logic [DRP_AW-1:0] drp_addr,
  output logic [DRP_DW-1:0] drp_di,
  input  logic [DRP_DW-1:0] drp_do,
  input  logic              drp_rdy
);

  logic              busy;
  logic [DRP_DW-1:0] rd_word;
  logic              cmd_wr;

  assign cmd_wr = bus_wr && (bus_waddr == CMD_OFFS);

  cfg_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DRP_DW(DRP_DW), .SEL_W(SEL_W),
    .RST_OFFS(RST_OFFS), .SEL_OFFS(SEL_OFFS), .STS_OFFS(STS_OFFS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_waddr(bus_waddr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
    .busy(busy), .rd_word(rd_word),
    .core_rst_n(core_rst_n), .synth_en(synth_en), .src_sel(src_sel)
  );

  drp_engine #(
    .DATA_W(DATA_W), .DRP_AW(DRP_AW), .DRP_DW(DRP_DW)
  ) u_eng (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr(cmd_wr), .cmd_data(bus_wdata),
    .busy(busy), .rd_word(rd_word),
    .drp_en(drp_en), .drp_we(drp_we), .drp_addr(drp_addr), .drp_di(drp_di),
    .drp_do(drp_do), .drp_rdy(drp_rdy)
  );

endmodule

// File: rtl/drp_cfg_bridge_chk.sv
module drp_cfg_bridge_chk #(
  parameter int DRP_AW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              drp_en,
  input logic              drp_we,
  input logic              drp_rdy,
  input logic [DRP_AW-1:0] drp_addr
);

  // R4
  en_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drp_en |=> !drp_en);

  // R5
  we_with_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drp_we |-> drp_en);

  // R6
  busy_covers_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drp_en |-> busy);

  // R6
  busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !drp_rdy) |=> busy);

  // R8
  launch_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drp_en |-> !$past(busy));

  // R8
  addr_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(drp_addr));

endmodule

bind drp_cfg_bridge drp_cfg_bridge_chk #(.DRP_AW(DRP_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .drp_en(drp_en),
  .drp_we(drp_we), .drp_rdy(drp_rdy), .drp_addr(drp_addr)
);

// File: tb/sim_drp_cfg_bridge.sv
module sim_drp_cfg_bridge;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_waddr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_raddr = '0;
  logic [31:0] bus_rdata;
  logic        core_rst_n, synth_en;
  logic [0:0]  src_sel;
  logic        drp_en, drp_we;
  logic [7:0]  drp_addr;
  logic [15:0] drp_di;
  logic [15:0] drp_do = '0;
  logic        drp_rdy = 1'b0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  drp_cfg_bridge u0 (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_waddr(bus_waddr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
    .core_rst_n(core_rst_n), .synth_en(synth_en), .src_sel(src_sel),
    .drp_en(drp_en), .drp_we(drp_we), .drp_addr(drp_addr), .drp_di(drp_di),
    .drp_do(drp_do), .drp_rdy(drp_rdy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_waddr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_raddr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic port_done(input logic [15:0] d);
    drp_rdy = 1'b1; drp_do = d;
    @(negedge clk);
    drp_rdy = 1'b0;
  endtask

  function automatic logic [31:0] cmd(input bit sel, input bit rd,
                                      input logic [7:0] a, input logic [15:0] d);
    return {2'b00, sel, rd, 4'h0, a, d};
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 core_rst_n", {31'd0, core_rst_n}, 0);
    chk("R1 synth_en", {31'd0, synth_en}, 0);
    chk("R1 src_sel", {31'd0, src_sel}, 0);
    chk("R1 drp_en/we", {30'd0, drp_en, drp_we}, 0);
    bus_read(8'h40, v); chk("R1 read 0x40", v, 0);
    bus_read(8'h44, v); chk("R1 read 0x44", v, 0);
    bus_read(8'h74, v); chk("R1 read 0x74", v, 0);
  endtask

  task automatic t_cfg();
    logic [31:0] v;
    bus_write(8'h40, 32'hFFFF_FFFF);
    chk("R2 core_rst_n set", {31'd0, core_rst_n}, 1);
    chk("R2 synth_en set", {31'd0, synth_en}, 1);
    bus_read(8'h40, v); chk("R2 readback", v, 32'h3);
    bus_write(8'h40, 32'h2);
    chk("R2 pins 2'b10", {30'd0, synth_en, core_rst_n}, 32'h2);
    bus_write(8'h44, 32'h1);
    chk("R3 src_sel set", {31'd0, src_sel}, 1);
    bus_read(8'h44, v); chk("R3 readback", v, 1);
    bus_write(8'h44, 32'hFFFE);
    chk("R3 src_sel clear", {31'd0, src_sel}, 0);
    bus_read(8'h44, v); chk("R3 readback zero", v, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    bus_read(8'h48, v); chk("R10 read 0x48", v, 0);
    bus_read(8'h00, v); chk("R10 read 0x00", v, 0);
    bus_read(8'h70, v); chk("R10 read 0x70", v, 0);
  endtask

  task automatic t_port_write();
    logic [31:0] v;
    bus_write(8'h70, cmd(1, 0, 8'h28, 16'h9800));
    chk("R4 en+we pulse", {30'd0, drp_en, drp_we}, 32'h3);
    chk("R4 addr", {24'd0, drp_addr}, 32'h28);
    chk("R4 data", {16'd0, drp_di}, 32'h9800);
    bus_read(8'h74, v);
    chk("R6 busy during write", v, 32'h0001_0000);
    chk("R4 en drops", {30'd0, drp_en, drp_we}, 0);
    repeat (2) @(negedge clk);
    port_done(16'hDEAD);
    bus_read(8'h74, v);
    chk("R7 write leaves data", v, 32'h0);
  endtask

  task automatic t_port_read();
    logic [31:0] v;
    bus_write(8'h70, cmd(1, 1, 8'h16, 16'h1234));
    chk("R5 en without we", {30'd0, drp_en, drp_we}, 32'h2);
    chk("R5 addr", {24'd0, drp_addr}, 32'h16);
    bus_read(8'h74, v);
    chk("R6 busy during read", v, 32'h0001_0000);
    port_done(16'hBEEF);
    bus_read(8'h74, v);
    chk("R7 read data", v, 32'h0000_BEEF);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    bus_write(8'h70, cmd(1, 1, 8'h08, 16'h0));
    chk("R5 launch 0x08", {24'd0, drp_addr}, 32'h08);
    @(negedge clk);
    bus_write(8'h70, cmd(1, 0, 8'h55, 16'h1111));
    chk("R8 busy write no pulse", {31'd0, drp_en}, 0);
    chk("R8 busy write addr kept", {24'd0, drp_addr}, 32'h08);
    drp_rdy = 1'b1; drp_do = 16'h0A0A;
    bus_write(8'h70, cmd(1, 0, 8'h66, 16'h2222));
    drp_rdy = 1'b0;
    chk("R8 same-cycle no pulse", {31'd0, drp_en}, 0);
    chk("R8 same-cycle addr kept", {24'd0, drp_addr}, 32'h08);
    bus_read(8'h74, v);
    chk("R8 completion data, idle", v, 32'h0000_0A0A);
    chk("R8 still no pulse", {31'd0, drp_en}, 0);
    bus_write(8'h70, cmd(1, 0, 8'h66, 16'h2222));
    chk("R8 new command accepted", {23'd0, drp_en, drp_addr}, 32'h166);
    @(negedge clk);
    port_done(16'h0);
  endtask

  task automatic t_nosel();
    logic [31:0] v;
    bus_write(8'h70, cmd(0, 1, 8'h77, 16'h3333));
    chk("R9 no pulse", {31'd0, drp_en}, 0);
    chk("R9 addr kept", {24'd0, drp_addr}, 32'h66);
    bus_read(8'h74, v);
    chk("R9 not busy", v, 32'h0000_0A0A);
  endtask

  task automatic t_stray();
    logic [31:0] v;
    port_done(16'h5555);
    bus_read(8'h74, v);
    chk("R11 stray ready ignored", v, 32'h0000_0A0A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_unmapped();
    t_port_write();
    t_port_read();
    t_collide();
    t_nosel();
    t_stray();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule